// File: doc/BRIEF.md
# Byte FIFO with Direction-Aware Watermark Interrupts

This block is a byte-wide first-in first-out store placed between a host register port and a line-side transmit/receive engine. In the transmit direction the host loads bytes and the line engine drains them. In the receive direction the line engine deposits bytes and the host drains them. The block keeps the current fill level and, separately, a count of bytes actually handed to the line during the running transmission.

An interrupt request tells the host when to act. While receiving, it asserts once the fill level climbs to a programmable high mark. While transmitting, it asserts once the fill level falls to a programmable low mark. A programmed 16-bit transmit length bounds the transmission. A host "last" strobe marks the end of the data: it ends a transmission once the store drains, or closes a reception.

The controller has four states:
- `ST_IDLE`: no transfer is running.
- `ST_TX_RUN`: a transmission is running.
- `ST_TX_DONE`: the transmission has finished.
- `ST_RX_RUN`: a reception is running.

Its transitions are:
- **start-tx**: `ST_IDLE` or `ST_TX_DONE` to `ST_TX_RUN`.
- **start-tx-empty**: `ST_IDLE` or `ST_TX_DONE` straight to `ST_TX_DONE` when the programmed length is zero.
- **start-rx**: `ST_IDLE` or `ST_TX_DONE` to `ST_RX_RUN`.
- **length-reached**: `ST_TX_RUN` to `ST_TX_DONE`.
- **drained-after-last**: `ST_TX_RUN` to `ST_TX_DONE`.
- **rx-close**: `ST_RX_RUN` to `ST_IDLE`.

Top module: `byte_wm_fifo`

## Requirements
- R1: After reset the block is in `ST_IDLE` with `level` = 0, `sent_cnt` = 0, and `irq`, `done`, `ovf` and `udf` all low. The configuration resets to receive mark 124, transmit mark 4 and transmit length 0.
- R2: Bytes leave the store in the order they were accepted. `level` equals accepted writes minus accepted reads, never exceeds 128, and `head_data` always shows the oldest byte.
- R3: A write while `level` is 128 is dropped and sets the sticky `ovf`. A read while `level` is 0 is dropped and sets the sticky `udf`. Both flags clear only on an accepted start.
- R4: The strobes are routed by state. In `ST_RX_RUN`, `line_push` writes and `host_pop` reads. In every other state, `host_push` writes and only `ST_TX_RUN` accepts `line_pop` reads. Strobes that do not belong to the current state change nothing.
- R5: `sent_cnt` increments by one on each accepted `line_pop` in `ST_TX_RUN` and clears on an accepted start.
- R6: When `sent_cnt` reaches the transmit length, the controller enters `ST_TX_DONE` and `done` goes high. Further `line_pop` strobes are ignored. A start toward transmit with length 0 goes straight to `ST_TX_DONE`.
- R7: With `cfg_we` high, `cfg_data` is written to the register picked by `cfg_sel`: 0 receive mark, 1 transmit mark, 2 length bits 7:0, 3 length bits 15:8. Writes are accepted in any state.
- R8: In `ST_RX_RUN`, `irq` is high while `level` is at or above the receive mark.
- R9: In `ST_TX_RUN`, `irq` is high while `level` is at or below the transmit mark, unless the last-byte flag is set. `irq` is low in `ST_IDLE` and `ST_TX_DONE`.
- R10: `irq_ack` while `irq` is high silences it for as long as the mark condition keeps holding. The request re-arms once the condition has gone false for a cycle.
- R11: `host_last` outside `ST_RX_RUN` sets the last-byte flag. In `ST_TX_RUN`, flag set with the store empty leads to `ST_TX_DONE`.
- R12: `host_last` in `ST_RX_RUN` returns the controller to `ST_IDLE`, after which `line_push` is ignored.
- R13: `start` is accepted only in `ST_IDLE` or `ST_TX_DONE`; `dir_tx` = 1 picks transmit and 0 picks receive. A `start` during a running transfer is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer |
| dir_tx | input | 1 | Direction for start: 1 transmit, 0 receive |
| host_push | input | 1 | Host write strobe |
| host_din | input | 8 | Host write byte |
| host_pop | input | 1 | Host read strobe (receive) |
| host_last | input | 1 | Host end-of-data mark |
| line_push | input | 1 | Line engine write strobe (receive) |
| line_din | input | 8 | Line engine write byte |
| line_pop | input | 1 | Line engine read strobe (transmit) |
| head_data | output | 8 | Oldest stored byte |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Configuration register select |
| cfg_data | input | 8 | Configuration write byte |
| irq_ack | input | 1 | Interrupt acknowledge |
| level | output | 8 | Current fill level |
| sent_cnt | output | 16 | Bytes transmitted in this transfer |
| irq | output | 1 | Watermark interrupt request |
| done | output | 1 | Transmission finished |
| ovf | output | 1 | Sticky write-when-full flag |
| udf | output | 1 | Sticky read-when-empty flag |

## Verification
The store is first filled by the host and drained by the line engine toward a short length bound. It is then filled by the line engine past the receive mark and on to overflow, and drained by the host. This separates the two routing modes and shows that order holds through a pointer wrap. The transmit sequence drops the level onto the low mark, acknowledges, stays below, refills and drops again, which tells silencing apart from re-arming. The last-byte drain, a zero-length start and a start during a running reception each select a different exit or non-exit of the controller.

// File: rtl/bwf_pkg.sv
package bwf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_TX_RUN  = 2'd1,
        ST_TX_DONE = 2'd2,
        ST_RX_RUN  = 2'd3
    } bwf_state_e;

    localparam logic [1:0] CFG_RX_MARK = 2'd0;
    localparam logic [1:0] CFG_TX_MARK = 2'd1;
    localparam logic [1:0] CFG_LEN_LO  = 2'd2;
    localparam logic [1:0] CFG_LEN_HI  = 2'd3;
endpackage

// File: rtl/bwf_store.sv
module bwf_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 128
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_req,
    input  logic [DW-1:0]              push_data,
    input  logic                       pop_req,
    output logic [DW-1:0]              head,
    output logic [$clog2(DEPTH):0]     level,
    output logic                       full,
    output logic                       empty,
    output logic                       push_ok,
    output logic                       pop_ok
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign push_ok = push_req && !full;
    assign pop_ok  = pop_req && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            unique case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/bwf_ctrl.sv
module bwf_ctrl
    import bwf_pkg::*;
#(
    parameter int DW   = 8,
    parameter int LENW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            dir_tx,
    input  logic            host_push,
    input  logic [DW-1:0]   host_din,
    input  logic            host_pop,
    input  logic            host_last,
    input  logic            line_push,
    input  logic [DW-1:0]   line_din,
    input  logic            line_pop,
    input  logic [LENW-1:0] tx_len,
    input  logic            full,
    input  logic            empty,
    input  logic            pop_ok,
    output logic            push_req,
    output logic [DW-1:0]   push_data,
    output logic            pop_req,
    output bwf_state_e      state,
    output logic [LENW-1:0] sent_cnt,
    output logic            last_seen,
    output logic            ovf,
    output logic            udf
);
    bwf_state_e state_nx;
    logic       start_ok;
    logic       len_hit;

    assign start_ok = start && (state == ST_IDLE || state == ST_TX_DONE);
    assign len_hit  = pop_ok && (({1'b0, sent_cnt} + 1'b1) == {1'b0, tx_len});

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_TX_DONE: begin
                if (start) begin
                    if (!dir_tx)           state_nx = ST_RX_RUN;
                    else if (tx_len == '0) state_nx = ST_TX_DONE;
                    else                   state_nx = ST_TX_RUN;
                end
            end
            ST_TX_RUN: begin
                if (len_hit)                state_nx = ST_TX_DONE;
                else if (last_seen && empty) state_nx = ST_TX_DONE;
            end
            ST_RX_RUN: begin
                if (host_last) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // strobe routing
    always_comb begin
        push_req  = host_push;
        push_data = host_din;
        pop_req   = 1'b0;
        unique case (state)
            ST_RX_RUN: begin
                push_req  = line_push;
                push_data = line_din;
                pop_req   = host_pop;
            end
            ST_TX_RUN: pop_req = line_pop;
            default:   pop_req = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sent_cnt  <= '0;
            last_seen <= 1'b0;
            ovf       <= 1'b0;
            udf       <= 1'b0;
        end else begin
            if (start_ok)                        sent_cnt <= '0;
            else if (state == ST_TX_RUN && pop_ok) sent_cnt <= sent_cnt + 1'b1;

            if (start_ok && !dir_tx)                            last_seen <= 1'b0;
            else if (state == ST_TX_RUN && state_nx == ST_TX_DONE) last_seen <= 1'b0;
            else if (host_last && state != ST_RX_RUN)           last_seen <= 1'b1;

            if (start_ok)             ovf <= 1'b0;
            else if (push_req && full) ovf <= 1'b1;

            if (start_ok)              udf <= 1'b0;
            else if (pop_req && empty) udf <= 1'b1;
        end
    end
endmodule

// File: rtl/bwf_irq.sv
module bwf_irq
    import bwf_pkg::*;
#(
    parameter int LW  = 8,
    parameter int WMW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  bwf_state_e     state,
    input  logic [LW-1:0]  level,
    input  logic [WMW-1:0] rx_mark,
    input  logic [WMW-1:0] tx_mark,
    input  logic           last_seen,
    input  logic           irq_ack,
    output logic           irq
);
    localparam int CW = (LW > WMW) ? LW : WMW;

    logic [CW-1:0] lvl_c;
    logic [CW-1:0] rx_c;
    logic [CW-1:0] tx_c;
    logic          cond;
    logic          silenced;

    assign lvl_c = CW'(level);
    assign rx_c  = CW'(rx_mark);
    assign tx_c  = CW'(tx_mark);

    always_comb begin
        unique case (state)
            ST_RX_RUN: cond = (lvl_c >= rx_c);
            ST_TX_RUN: cond = !last_seen && (lvl_c <= tx_c);
            default:   cond = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       silenced <= 1'b0;
        else if (!cond)   silenced <= 1'b0;
        else if (irq_ack) silenced <= 1'b1;
    end

    assign irq = cond && !silenced;
endmodule

// File: rtl/byte_wm_fifo.sv
module byte_wm_fifo
    import bwf_pkg::*;
#(
    parameter int DW         = 8,
    parameter int DEPTH      = 128,
    parameter int WMW        = 8,
    parameter int RX_WM_INIT = 124,
    parameter int TX_WM_INIT = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   dir_tx,
    input  logic                   host_push,
    input  logic [DW-1:0]          host_din,
    input  logic                   host_pop,
    input  logic                   host_last,
    input  logic                   line_push,
    input  logic [DW-1:0]          line_din,
    input  logic                   line_pop,
    output logic [DW-1:0]          head_data,
    input  logic                   cfg_we,
    input  logic [1:0]             cfg_sel,
    input  logic [7:0]             cfg_data,
    input  logic                   irq_ack,
    output logic [$clog2(DEPTH):0] level,
    output logic [15:0]            sent_cnt,
    output logic                   irq,
    output logic                   done,
    output logic                   ovf,
    output logic                   udf
);
    localparam int LW   = $clog2(DEPTH) + 1;
    localparam int LENW = 16;

    logic [WMW-1:0]  rx_mark;
    logic [WMW-1:0]  tx_mark;
    logic [LENW-1:0] tx_len;
    logic            push_req;
    logic [DW-1:0]   push_data;
    logic            pop_req;
    logic            full;
    logic            empty;
    logic            push_ok;
    logic            pop_ok;
    logic            last_seen;
    bwf_state_e      st;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_mark <= WMW'(RX_WM_INIT);
            tx_mark <= WMW'(TX_WM_INIT);
            tx_len  <= '0;
        end else if (cfg_we) begin
            unique case (cfg_sel)
                CFG_RX_MARK: rx_mark      <= WMW'(cfg_data);
                CFG_TX_MARK: tx_mark      <= WMW'(cfg_data);
                CFG_LEN_LO:  tx_len[7:0]  <= cfg_data;
                CFG_LEN_HI:  tx_len[15:8] <= cfg_data;
                default:     tx_len       <= tx_len;
            endcase
        end
    end

    bwf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n),
        .push_req(push_req), .push_data(push_data), .pop_req(pop_req),
        .head(head_data), .level(level), .full(full), .empty(empty),
        .push_ok(push_ok), .pop_ok(pop_ok)
    );

    bwf_ctrl #(.DW(DW), .LENW(LENW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_tx(dir_tx),
        .host_push(host_push), .host_din(host_din), .host_pop(host_pop),
        .host_last(host_last), .line_push(line_push), .line_din(line_din),
        .line_pop(line_pop), .tx_len(tx_len), .full(full), .empty(empty),
        .pop_ok(pop_ok), .push_req(push_req), .push_data(push_data),
        .pop_req(pop_req), .state(st), .sent_cnt(sent_cnt),
        .last_seen(last_seen), .ovf(ovf), .udf(udf)
    );

    bwf_irq #(.LW(LW), .WMW(WMW)) u_irq (
        .clk(clk), .rst_n(rst_n), .state(st), .level(level),
        .rx_mark(rx_mark), .tx_mark(tx_mark), .last_seen(last_seen),
        .irq_ack(irq_ack), .irq(irq)
    );

    assign done = (st == ST_TX_DONE);
endmodule

// File: rtl/bwf_chk.sv
module bwf_chk
    import bwf_pkg::*;
#(
    parameter int DEPTH = 128
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic                   host_pop,
    input logic                   line_pop,
    input logic [$clog2(DEPTH):0] level,
    input logic [15:0]            sent_cnt,
    input logic                   irq,
    input logic                   done,
    input logic                   ovf,
    input bwf_state_e             st
);
    p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        level <= ($clog2(DEPTH)+1)'(DEPTH));

    p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (level == ($clog2(DEPTH)+1)'(DEPTH) && !host_pop && !line_pop) |=> level == ($clog2(DEPTH)+1)'(DEPTH));

    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !start) |=> ovf);

    p_sent_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (sent_cnt == $past(sent_cnt) || sent_cnt == $past(sent_cnt) + 16'd1));

    p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !irq);

    p_irq_running_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (st == ST_TX_RUN || st == ST_RX_RUN));

    p_run_no_restart_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RX_RUN && start) |=> st != ST_TX_RUN);
endmodule

bind byte_wm_fifo bwf_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .host_pop(host_pop),
    .line_pop(line_pop), .level(level), .sent_cnt(sent_cnt), .irq(irq),
    .done(done), .ovf(ovf), .st(st)
);

// File: tb/byte_wm_fifo_tb.sv
module byte_wm_fifo_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 0, dir_tx = 0;
    logic       host_push = 0, host_pop = 0, host_last = 0;
    logic [7:0] host_din = 0;
    logic       line_push = 0, line_pop = 0;
    logic [7:0] line_din = 0;
    logic [7:0] head_data;
    logic       cfg_we = 0;
    logic [1:0] cfg_sel = 0;
    logic [7:0] cfg_data = 0;
    logic       irq_ack = 0;
    logic [7:0] level;
    logic [15:0] sent_cnt;
    logic       irq, done, ovf, udf;

    int n_chk = 0;
    int n_bad = 0;
    bit reported = 0;
    logic mon_en = 0;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;

    byte_wm_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_tx(dir_tx),
        .host_push(host_push), .host_din(host_din), .host_pop(host_pop),
        .host_last(host_last), .line_push(line_push), .line_din(line_din),
        .line_pop(line_pop), .head_data(head_data), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_data(cfg_data), .irq_ack(irq_ack),
        .level(level), .sent_cnt(sent_cnt), .irq(irq), .done(done),
        .ovf(ovf), .udf(udf)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        end
        $finish;
    endtask

    // monitor: compares the oldest byte against the scoreboard on every expected read
    always @(posedge clk) begin
        if (mon_en) begin
            if (exp_q.size() == 0) begin
                check(0, "R2 scoreboard empty", 0, 1);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                check(head_data == e, "R2 order", head_data, e);
            end
        end
    end

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic cfg(input logic [1:0] s, input logic [7:0] d);
        cfg_we = 1; cfg_sel = s; cfg_data = d; cyc(); cfg_we = 0;
    endtask

    task automatic go(input logic tx);
        start = 1; dir_tx = tx; cyc(); start = 0;
    endtask

    task automatic hpush(input logic [7:0] b, input bit keep);
        host_push = 1; host_din = b;
        if (keep) exp_q.push_back(b);
        cyc(); host_push = 0;
    endtask

    task automatic lpush(input logic [7:0] b, input bit keep);
        line_push = 1; line_din = b;
        if (keep) exp_q.push_back(b);
        cyc(); line_push = 0;
    endtask

    task automatic lpop(input bit expect_ok);
        line_pop = 1; mon_en = expect_ok; cyc(); line_pop = 0; mon_en = 0;
    endtask

    task automatic hpop(input bit expect_ok);
        host_pop = 1; mon_en = expect_ok; cyc(); host_pop = 0; mon_en = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        // R1 reset state
        check(level == 0 && sent_cnt == 0, "R1 counters", level, 0);
        check(!irq && !done && !ovf && !udf, "R1 flags", {irq, done, ovf, udf}, 0);

        // R7 length 6 (low byte at sel 2, high byte at sel 3)
        cfg(2'd2, 8'd6);
        cfg(2'd3, 8'd0);
        for (int i = 0; i < 5; i++) hpush(8'h10 + 8'(i), 1);
        check(level == 5, "R2 level after loads", level, 5);
        lpop(0);
        check(level == 5, "R4 line read ignored in idle", level, 5);

        // transmit run
        go(1);
        check(!irq, "R9 above low mark", irq, 0);
        lpop(1);
        check(irq && level == 4, "R9 default low mark 4", irq, 1);
        irq_ack = 1; cyc(); irq_ack = 0;
        check(!irq, "R10 ack silences", irq, 0);
        lpop(1);
        check(!irq && level == 3, "R10 stays silenced", irq, 0);
        hpush(8'h20, 1);
        hpush(8'h21, 1);
        check(!irq && level == 5, "R10 condition gone", level, 5);
        lpop(1);
        check(irq, "R10 rearmed", irq, 1);
        check(sent_cnt == 3, "R5 sent count", sent_cnt, 3);
        lpop(1); lpop(1);
        check(!done, "R6 not yet", done, 0);
        lpop(1);
        check(done && sent_cnt == 6, "R6 length reached", sent_cnt, 6);
        check(!irq, "R9 quiet when done", irq, 0);
        lpop(0);
        check(level == 1, "R6 read after done ignored", level, 1);

        // receive run
        go(0);
        check(sent_cnt == 0, "R5 cleared on start", sent_cnt, 0);
        hpop(1);
        check(level == 0, "R4 host read in rx", level, 0);
        hpop(0);
        check(udf && level == 0, "R3 underflow", udf, 1);
        hpush(8'hEE, 0);
        check(level == 0, "R4 host write ignored in rx", level, 0);
        for (int i = 0; i < 123; i++) lpush(8'(i * 3 + 1), 1);
        check(!irq && level == 123, "R8 below default high mark", irq, 0);
        lpush(8'hA5, 1);
        check(irq && level == 124, "R8 default high mark 124", irq, 1);
        go(1);
        lpush(8'hA6, 1);
        check(level == 125, "R13 start ignored in rx", level, 125);
        for (int i = 0; i < 3; i++) lpush(8'hB0 + 8'(i), 1);
        check(level == 128 && !ovf, "R2 full", level, 128);
        lpush(8'hFF, 0);
        check(ovf && level == 128, "R3 overflow", ovf, 1);
        cfg(2'd0, 8'd200);
        check(!irq, "R7 receive mark written", irq, 0);
        for (int i = 0; i < 128; i++) hpop(1);
        check(level == 0, "R2 drained", level, 0);
        host_last = 1; cyc(); host_last = 0;
        lpush(8'h55, 0);
        check(level == 0, "R12 rx closed", level, 0);

        // last-byte drain, length high byte
        cfg(2'd2, 8'd0);
        cfg(2'd3, 8'd1);
        go(1);
        check(!ovf && !udf, "R3 cleared by start", {ovf, udf}, 0);
        check(!done, "R7 length high byte", done, 0);
        check(irq, "R9 empty below mark", irq, 1);
        hpush(8'h61, 1);
        hpush(8'h62, 1);
        host_last = 1; cyc(); host_last = 0;
        check(!irq, "R11 last suppresses irq", irq, 0);
        lpop(1); lpop(1);
        cyc();
        check(done && sent_cnt == 2, "R11 drained after last", sent_cnt, 2);

        // zero length start from done
        cfg(2'd2, 8'd0);
        cfg(2'd3, 8'd0);
        go(1);
        check(done && sent_cnt == 0, "R6 zero length", sent_cnt, 0);
        check(exp_q.size() == 0, "R2 all bytes seen", exp_q.size(), 0);

        report();
    end
endmodule